// File: doc/BRIEF.md
# Three-Lane Micro-Op Group Packer

This block sits between instruction decode and a reorder buffer organised as three lanes per row. Decode hands it up to three micro-ops per cycle, each tagged with an operation class. The block queues them in a small store and forms one group per cycle from the oldest queued micro-ops. Inside each group, every micro-op is given a lane. The lane fixes which downstream scheduler receives that micro-op, so placement follows two hard rules: multiplies go to the first lane, and bit-count operations go to the last lane. As a soft rule, generic operations avoid lanes whose scheduler reports itself full.

Groups are formed strictly in program order. When the next micro-op has no legal free lane, the group closes and its unused lanes are marked empty. The leftover micro-op then starts the following group. The reorder buffer takes a group only when it signals readiness. A flush discards everything queued.

Top module: `uop_pack_buffer`

## Requirements
- R1: Whenever the buffer holds at least one micro-op and no flush is applied, `grp_valid` is 1 and at least one lane is valid. When `rob_ready` is also 1, the micro-ops shown in the group leave the buffer at that clock edge. At most one group leaves per cycle.
- R2: A micro-op of class multiply (class code 2'b01) is only ever placed in lane 0.
- R3: A micro-op of class count (class code 2'b10) is only ever placed in lane 2.
- R4: A generic micro-op (class codes 2'b00 and 2'b11) takes the lowest still-free lane whose `sched_full` bit is 0. If every free lane is flagged full, it takes the lowest free lane.
- R5: Micro-ops are considered oldest first. The first one that has no legal free lane closes the group, and no younger micro-op joins that group. Lanes left unfilled have their `lane_valid` bit at 0.
- R6: While `rob_ready` is 0, nothing leaves the buffer, and the same oldest micro-ops are presented again in the next cycle.
- R7: The buffer holds 6 micro-ops. `in_ready` is 1 exactly when at least 3 entries are free. Input micro-ops offered while `in_ready` is 0 are dropped.
- R8: Valid input slots are queued in slot order (slot 0 oldest) and packed together. Slots whose `in_valid` bit is 0 are skipped. Each lane carries the class and payload of the micro-op placed there.
- R9: `flush` empties the buffer at the next clock edge. In a flush cycle `grp_valid` and all `lane_valid` bits are 0, and that cycle's inputs are dropped.
- R10: During and right after reset, the buffer is empty, `grp_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all queued micro-ops |
| in_valid | input | 3 | Per-slot valid of incoming micro-ops |
| in_class | input | 6 | Class code per slot, slot i at bits [2i+1:2i] |
| in_data | input | 24 | Payload per slot, slot i at bits [8i+7:8i] |
| in_ready | output | 1 | At least three free entries |
| sched_full | input | 3 | Per-lane downstream scheduler full flag |
| rob_ready | input | 1 | Reorder buffer accepts a group this cycle |
| grp_valid | output | 1 | A group is presented |
| lane_valid | output | 3 | Per-lane valid of the presented group |
| lane_class | output | 6 | Class code per lane, lane l at bits [2l+1:2l] |
| lane_data | output | 24 | Payload per lane, lane l at bits [8l+7:8l] |

## Verification
Enqueue and release often share a cycle. New micro-ops can be accepted in the same edge that a group drains, and flush can coincide with both. The stimulus drives bursts of input together with random `rob_ready` and rare flushes, so all three kinds of cycle occur. A bench model checks that acceptance depends on the occupancy before the edge, that the released count equals the group size, and that a flush overrides both.

// File: rtl/upb_pkg.sv
package upb_pkg;
  typedef enum logic [1:0] {
    UC_GEN = 2'b00,
    UC_MUL = 2'b01,
    UC_CNT = 2'b10,
    UC_ALT = 2'b11
  } uop_cls_e;
endpackage

// File: rtl/upb_lane_picker.sv
module upb_lane_picker
  import upb_pkg::*;
#(
  parameter  int LANES = 3,
  localparam int SEL_W = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]            cand_vld,
  input  logic [LANES-1:0][1:0]       cand_cls,
  input  logic [LANES-1:0]            sched_full,
  output logic [LANES-1:0]            lane_vld,
  output logic [LANES-1:0][SEL_W-1:0] lane_sel,
  output logic [CNT_W-1:0]            take_cnt
);
  localparam int MUL_LANE = 0;
  localparam int CNT_LANE = LANES - 1;

  logic [LANES-1:0] used;
  logic             grp_open;
  int               pick;

  // Oldest-first placement; first unplaceable micro-op closes the group.
  always_comb begin
    used     = '0;
    lane_sel = '0;
    take_cnt = '0;
    grp_open = 1'b1;
    pick     = -1;
    for (int i = 0; i < LANES; i++) begin
      pick = -1;
      if (grp_open && cand_vld[i]) begin
        if (cand_cls[i] == UC_MUL) begin
          if (!used[MUL_LANE]) pick = MUL_LANE;
        end else if (cand_cls[i] == UC_CNT) begin
          if (!used[CNT_LANE]) pick = CNT_LANE;
        end else begin
          for (int l = 0; l < LANES; l++)
            if (pick < 0 && !used[l] && !sched_full[l]) pick = l;
          for (int l = 0; l < LANES; l++)
            if (pick < 0 && !used[l]) pick = l;
        end
        if (pick >= 0) begin
          used[pick]     = 1'b1;
          lane_sel[pick] = SEL_W'(i);
          take_cnt       = take_cnt + CNT_W'(1);
        end else begin
          grp_open = 1'b0;
        end
      end else begin
        grp_open = 1'b0;
      end
    end
    lane_vld = used;
  end
endmodule

// File: rtl/upb_store.sv
module upb_store #(
  parameter  int DEPTH = 6,
  parameter  int LANES = 3,
  parameter  int EW    = 10,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TK_W  = $clog2(LANES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [LANES-1:0]         push_vld,
  input  logic [LANES-1:0][EW-1:0] push_ent,
  input  logic [TK_W-1:0]          pop_cnt,
  output logic [LANES-1:0]         head_vld,
  output logic [LANES-1:0][EW-1:0] head_ent,
  output logic                     room_ok
);
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic [EW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] wr_en;
  logic [EW-1:0]    wr_dat [DEPTH];
  logic             accept;
  int               pos;

  function automatic logic [PTR_W-1:0] wrap_add(logic [PTR_W-1:0] base, int off);
    int s;
    s = int'(base) + off;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign room_ok = (int'(occ_q) <= DEPTH - LANES);
  assign accept  = room_ok && !flush;

  always_comb begin
    wr_en = '0;
    pos   = 0;
    for (int e = 0; e < DEPTH; e++) wr_dat[e] = '0;
    for (int i = 0; i < LANES; i++) begin
      if (accept && push_vld[i]) begin
        wr_en[wrap_add(wr_q, pos)]  = 1'b1;
        wr_dat[wrap_add(wr_q, pos)] = push_ent[i];
        pos = pos + 1;
      end
    end
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      occ_d = '0;
    end else begin
      rd_d  = wrap_add(rd_q, int'(pop_cnt));
      wr_d  = wrap_add(wr_q, pos);
      occ_d = occ_q + CNT_W'(pos) - CNT_W'(pop_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++)
      if (wr_en[e]) mem_q[e] <= wr_dat[e];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      head_vld[i] = int'(occ_q) > i;
      head_ent[i] = mem_q[wrap_add(rd_q, i)];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CNT_W'(DEPTH)) else $error("occupancy above depth"); // R7
  AST_POP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_cnt) <= int'(occ_q)) else $error("pop beyond occupancy"); // R5
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld[0] && pop_cnt == '0 && !flush) |=> (head_ent[0] == $past(head_ent[0])))
    else $error("oldest entry changed while held"); // R6
endmodule

// File: rtl/uop_pack_buffer.sv
module uop_pack_buffer
  import upb_pkg::*;
#(
  parameter  int DEPTH = 6,
  parameter  int LANES = 3,
  parameter  int W     = 8,
  localparam int EW    = W + 2,
  localparam int SEL_W = $clog2(LANES),
  localparam int TK_W  = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [LANES-1:0]   in_valid,
  input  logic [2*LANES-1:0] in_class,
  input  logic [W*LANES-1:0] in_data,
  output logic               in_ready,
  input  logic [LANES-1:0]   sched_full,
  input  logic               rob_ready,
  output logic               grp_valid,
  output logic [LANES-1:0]   lane_valid,
  output logic [2*LANES-1:0] lane_class,
  output logic [W*LANES-1:0] lane_data
);
  logic [LANES-1:0][EW-1:0]    push_ent, head_ent;
  logic [LANES-1:0]            head_vld, pick_vld, cand_vld;
  logic [LANES-1:0][1:0]       cand_cls;
  logic [LANES-1:0][SEL_W-1:0] pick_sel;
  logic [TK_W-1:0]             take_cnt, pop_cnt;

  generate
    for (genvar s = 0; s < LANES; s++) begin : g_slot
      assign push_ent[s] = {in_class[2*s +: 2], in_data[W*s +: W]};
      assign cand_cls[s] = head_ent[s][EW-1 -: 2];
    end
  endgenerate

  assign cand_vld = flush ? '0 : head_vld;

  upb_store #(.DEPTH(DEPTH), .LANES(LANES), .EW(EW)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push_vld (in_valid),
    .push_ent (push_ent),
    .pop_cnt  (pop_cnt),
    .head_vld (head_vld),
    .head_ent (head_ent),
    .room_ok  (in_ready)
  );

  upb_lane_picker #(.LANES(LANES)) picker_i (
    .cand_vld   (cand_vld),
    .cand_cls   (cand_cls),
    .sched_full (sched_full),
    .lane_vld   (pick_vld),
    .lane_sel   (pick_sel),
    .take_cnt   (take_cnt)
  );

  assign grp_valid  = head_vld[0] && !flush;
  assign lane_valid = pick_vld;
  assign pop_cnt    = (grp_valid && rob_ready) ? take_cnt : '0;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_class[2*l +: 2] = pick_vld[l] ? head_ent[pick_sel[l]][EW-1 -: 2] : 2'b00;
      assign lane_data[W*l +: W]  = pick_vld[l] ? head_ent[pick_sel[l]][W-1:0] : '0;
      if (l != 0) begin : g_not_mul
        AST_MUL_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
          lane_valid[l] |-> (lane_class[2*l +: 2] != UC_MUL)) else $error("multiply off lane 0"); // R2
      end
      if (l != LANES - 1) begin : g_not_cnt
        AST_CNT_LANE2: assert property (@(posedge clk) disable iff (!rst_n)
          lane_valid[l] |-> (lane_class[2*l +: 2] != UC_CNT)) else $error("count op off last lane"); // R3
      end
    end
  endgenerate

  AST_GROUP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> (lane_valid != '0)) else $error("empty group presented"); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !grp_valid) else $error("buffer not empty after flush"); // R9
endmodule

// File: tb/uop_pack_buffer_tb_top.sv
`timescale 1ns/1ps
module uop_pack_buffer_tb_top;
  localparam int W = 8;
  localparam int DEPTH = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, flush, in_ready, rob_ready, grp_valid;
  logic [2:0]   in_valid, sched_full, lane_valid;
  logic [5:0]   in_class, lane_class;
  logic [23:0]  in_data, lane_data;

  uop_pack_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_class(in_class), .in_data(in_data), .in_ready(in_ready),
    .sched_full(sched_full), .rob_ready(rob_ready), .grp_valid(grp_valid),
    .lane_valid(lane_valid), .lane_class(lane_class), .lane_data(lane_data)
  );

  int checks = 0;
  int fails  = 0;
  logic [1:0]   mcls [0:DEPTH-1];
  logic [W-1:0] mdat [0:DEPTH-1];
  int           mcnt = 0;
  logic [W-1:0] tag = 8'h10;
  logic [2:0]   elv;
  logic [1:0]   ecls [0:2];
  logic [W-1:0] edat [0:2];
  int           ek;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected group from the model, following R2-R5.
  task automatic predict(logic [2:0] sf);
    logic [2:0] used;
    bit open;
    int pick;
    used = 3'b000; open = 1; ek = 0;
    for (int l = 0; l < 3; l++) begin ecls[l] = 2'b00; edat[l] = '0; end
    for (int i = 0; i < 3; i++) begin
      pick = -1;
      if (open && i < mcnt) begin
        if (mcls[i] == 2'b01) begin
          if (!used[0]) pick = 0;
        end else if (mcls[i] == 2'b10) begin
          if (!used[2]) pick = 2;
        end else begin
          for (int l = 0; l < 3; l++) if (pick < 0 && !used[l] && !sf[l]) pick = l;
          for (int l = 0; l < 3; l++) if (pick < 0 && !used[l]) pick = l;
        end
        if (pick >= 0) begin
          used[pick] = 1'b1; ecls[pick] = mcls[i]; edat[pick] = mdat[i]; ek++;
        end else open = 0;
      end else open = 0;
    end
    elv = used;
  endtask

  task automatic cycle(logic [2:0] iv, logic [5:0] ic, logic fl, logic [2:0] sf, logic rr, string req);
    bit acc;
    @(negedge clk);
    in_valid = iv; in_class = ic; flush = fl; sched_full = sf; rob_ready = rr;
    in_data = {tag + 8'd2, tag + 8'd1, tag};
    #1;
    predict(sf);
    if (fl) elv = 3'b000;
    chk("R1", "grp_valid", 32'(grp_valid), 32'(mcnt > 0 && !fl));
    chk("R7", "in_ready", 32'(in_ready), 32'((DEPTH - mcnt) >= 3));
    chk(req, "lane_valid", 32'(lane_valid), 32'(elv));
    for (int l = 0; l < 3; l++) begin
      if (elv[l]) begin
        chk(req, "lane_class", 32'(lane_class[2*l +: 2]), 32'(ecls[l]));
        chk("R8", "lane_data", 32'(lane_data[8*l +: 8]), 32'(edat[l]));
      end
    end
    acc = (DEPTH - mcnt) >= 3;
    if (fl) mcnt = 0;
    else begin
      if (rr && mcnt > 0) begin
        for (int j = 0; j < DEPTH - ek; j++) begin mcls[j] = mcls[j+ek]; mdat[j] = mdat[j+ek]; end
        mcnt -= ek;
      end
      if (acc)
        for (int s = 0; s < 3; s++)
          if (iv[s]) begin mcls[mcnt] = ic[2*s +: 2]; mdat[mcnt] = tag + 8'(s); mcnt++; end
    end
    tag = tag + 8'd3;
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [5:0]  rc;
    seed = $urandom(32'h5A17C0DE);
    rst_n = 1'b0; flush = 0; in_valid = 0; in_class = 0; in_data = 0;
    sched_full = 0; rob_ready = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "grp_valid in reset", 32'(grp_valid), 32'd0);
    chk("R10", "in_ready in reset", 32'(in_ready), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R10");
    // GEN, MUL, GEN: MUL cannot follow GEN in lane 0
    cycle(3'b111, {2'b00, 2'b01, 2'b00}, 0, 3'b000, 0, "R8");
    cycle(3'b000, 6'h00, 0, 3'b000, 0, "R6");
    cycle(3'b000, 6'h00, 0, 3'b000, 0, "R6");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R5");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R2");
    // CNT, GEN, MUL with lane 0 flagged full
    cycle(3'b111, {2'b01, 2'b00, 2'b10}, 0, 3'b000, 0, "R8");
    cycle(3'b000, 6'h00, 0, 3'b001, 1, "R3");
    // all lanes full: generic falls back to lowest free lane
    cycle(3'b111, 6'h00, 0, 3'b111, 0, "R8");
    cycle(3'b000, 6'h00, 0, 3'b111, 1, "R4");
    cycle(3'b111, {2'b11, 2'b00, 2'b00}, 0, 3'b010, 0, "R8");
    cycle(3'b000, 6'h00, 0, 3'b010, 1, "R4");
    // MUL, MUL: second starts next group
    cycle(3'b011, {2'b00, 2'b01, 2'b01}, 0, 3'b000, 0, "R8");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R2");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R2");
    // fill to capacity, offer more while not ready
    cycle(3'b111, 6'h00, 0, 3'b000, 0, "R7");
    cycle(3'b111, 6'h00, 0, 3'b000, 0, "R7");
    cycle(3'b111, {2'b01, 2'b01, 2'b01}, 0, 3'b000, 0, "R7");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R7");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R7");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R7");
    // flush with inputs and release requested
    cycle(3'b111, 6'h00, 0, 3'b000, 0, "R8");
    cycle(3'b111, 6'h00, 1, 3'b000, 1, "R9");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R9");
    // sparse slots
    cycle(3'b101, {2'b10, 2'b01, 2'b01}, 0, 3'b000, 0, "R8");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R8");
    cycle(3'b000, 6'h00, 0, 3'b000, 1, "R5");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      for (int s = 0; s < 3; s++) begin
        int r;
        r = int'($urandom_range(0, 9));
        rc[2*s +: 2] = (r < 5) ? 2'b00 : (r < 7) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
      end
      cycle(3'($urandom), rc, ($urandom_range(0, 49) == 0), 3'($urandom),
            ($urandom_range(0, 3) != 0), "R1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule